// File: doc/BRIEF.md
# UART FIFO Watermark Interrupt Unit

This block keeps the occupancy counts of a UART's transmit and receive FIFOs and turns changes in those counts into four sticky interrupt sources for software. Push and pop strobes move each count. The unit does not model the data storage, the serializer or the baud generator; it tracks only how full each FIFO is.

The transmit side raises a refill request when its count falls strictly below a programmed watermark. It also raises a completion event when it drains to zero, so the end of a transfer is always visible whatever watermark is set. The receive side raises a drain request when its count reaches or passes its watermark, and an overflow event when a byte arrives at a full FIFO and is lost. Software clears each status bit by writing a one to it. A mask selects which bits drive the single interrupt line.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each level ranges from 0 to 16. A push alone adds one, a pop alone subtracts one, a push together with a pop leaves the level unchanged, and a pop at level 0 is ignored.
- R2: A TX push at level 16 without a pop is dropped. The TX level stays at 16 and no status bit is set.
- R3: Status bit positions: bit 0 TX watermark, bit 1 TX empty, bit 2 RX watermark, bit 3 RX overflow. After reset both levels and all status bits are 0.
- R4: Bit 0 sets on the clock edge where the TX level moves from not below to strictly below the TX watermark. With watermark 1 this happens only on reaching 0. With watermark 16 it happens on reaching 15. A change of the watermark alone sets nothing.
- R5: Bit 1 sets on the clock edge where the TX level moves from a nonzero value to 0.
- R6: Bit 2 sets on the clock edge where the RX level moves from below the RX watermark to equal to or above it. With watermark 1, a single byte into an empty FIFO sets it on the same edge that the level becomes 1.
- R7: An RX push at level 16 without a pop leaves the level at 16 and sets bit 3 on that same edge. A push together with a pop at level 16 is not an overflow.
- R8: Status bits are sticky. When clr_we_i is high, each bit with a 1 in clr_data_i is cleared. A 0 in clr_data_i has no effect.
- R9: A bit cleared while its condition still holds is not set again until the condition has gone false and then true.
- R10: If a bit's set event and its clear arrive on the same edge, the set wins.
- R11: irq_o is high when any status bit and its matching irq_en_i bit are both 1. Status bits latch regardless of irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Byte written into TX FIFO |
| tx_pop_i | input | 1 | Byte taken by transmitter |
| rx_push_i | input | 1 | Byte received into RX FIFO |
| rx_pop_i | input | 1 | Byte read by software |
| tx_wmark_i | input | 5 | TX watermark (0..16) |
| rx_wmark_i | input | 5 | RX watermark (0..16) |
| irq_en_i | input | 4 | Per-source interrupt enable |
| clr_we_i | input | 1 | Status clear strobe |
| clr_data_i | input | 4 | Bits to clear (write one to clear) |
| tx_level_o | output | 5 | TX FIFO occupancy |
| rx_level_o | output | 5 | RX FIFO occupancy |
| irq_status_o | output | 4 | Sticky interrupt status |
| irq_o | output | 1 | Combined, masked interrupt |

## Verification
The hardest case to reach is the re-arm rule. A status bit has to be cleared while its condition still holds. The level then has to leave the condition and return before the bit sets again. The stimulus leaves the TX FIFO below its watermark after clearing. It then cycles the level between 0 and 1, which must set TX empty again but not TX watermark. Finally it lifts the level to the watermark and drops it once, which must set TX watermark. The boundary watermarks 1 and 16 are reached by filling the TX FIFO completely and then draining it one entry at a time.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int NUM_IRQ    = 4;
  localparam int IRQ_TX_WM  = 0;
  localparam int IRQ_TX_EMP = 1;
  localparam int IRQ_RX_WM  = 2;
  localparam int IRQ_RX_OVF = 3;
  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/uart_fifo_level.sv
`timescale 1ns/1ps
module uart_fifo_level #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] level_nxt_o,
  output logic          full_o
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [LW-1:0] lvl_q, lvl_d;
  logic          empty;

  assign full_o = (lvl_q == FULL_LVL);
  assign empty  = (lvl_q == '0);

  always_comb begin
    lvl_d = lvl_q;
    if (push_i && !pop_i && !full_o)      lvl_d = lvl_q + LW'(1);
    else if (pop_i && !push_i && !empty)  lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign level_o     = lvl_q;
  assign level_nxt_o = lvl_d;
endmodule

// File: rtl/uart_irq_bit.sv
`timescale 1ns/1ps
module uart_irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= set_i | (q & ~clr_i);
  end
  assign q_o = q;
endmodule

// File: rtl/uart_fifo_irq.sv
`timescale 1ns/1ps
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_push_i,
  input  logic                tx_pop_i,
  input  logic                rx_push_i,
  input  logic                rx_pop_i,
  input  logic [LW-1:0]       tx_wmark_i,
  input  logic [LW-1:0]       rx_wmark_i,
  input  logic [NUM_IRQ-1:0]  irq_en_i,
  input  logic                clr_we_i,
  input  logic [NUM_IRQ-1:0]  clr_data_i,
  output logic [LW-1:0]       tx_level_o,
  output logic [LW-1:0]       rx_level_o,
  output logic [NUM_IRQ-1:0]  irq_status_o,
  output logic                irq_o
);
  logic [LW-1:0] tx_lvl, tx_nxt, rx_lvl, rx_nxt;
  logic          tx_full, rx_full;
  irq_vec_t      set_vec, clr_vec, status;

  uart_fifo_level #(.DEPTH(DEPTH), .LW(LW)) u_tx_lvl (
    .clk_i, .rst_ni, .push_i(tx_push_i), .pop_i(tx_pop_i),
    .level_o(tx_lvl), .level_nxt_o(tx_nxt), .full_o(tx_full)
  );

  uart_fifo_level #(.DEPTH(DEPTH), .LW(LW)) u_rx_lvl (
    .clk_i, .rst_ni, .push_i(rx_push_i), .pop_i(rx_pop_i),
    .level_o(rx_lvl), .level_nxt_o(rx_nxt), .full_o(rx_full)
  );

  // conditions compared on current and next level: a rise is a crossing by level movement
  logic tx_wm_now, tx_wm_nxt, rx_wm_now, rx_wm_nxt;
  assign tx_wm_now = (tx_lvl < tx_wmark_i);
  assign tx_wm_nxt = (tx_nxt < tx_wmark_i);
  assign rx_wm_now = (rx_lvl >= rx_wmark_i);
  assign rx_wm_nxt = (rx_nxt >= rx_wmark_i);

  always_comb begin
    set_vec             = '0;
    set_vec[IRQ_TX_WM]  = tx_wm_nxt & ~tx_wm_now;
    set_vec[IRQ_TX_EMP] = (tx_nxt == '0) & (tx_lvl != '0);
    set_vec[IRQ_RX_WM]  = rx_wm_nxt & ~rx_wm_now;
    set_vec[IRQ_RX_OVF] = rx_push_i & ~rx_pop_i & rx_full;
  end

  assign clr_vec = clr_we_i ? clr_data_i : '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_stat
    uart_irq_bit u_bit (
      .clk_i, .rst_ni, .set_i(set_vec[i]), .clr_i(clr_vec[i]), .q_o(status[i])
    );
  end

  // full TX is tracked but not reported: pushes at full are simply dropped
  logic tx_full_unused;
  assign tx_full_unused = tx_full;

  assign tx_level_o   = tx_lvl;
  assign rx_level_o   = rx_lvl;
  assign irq_status_o = status;
  assign irq_o        = |(status & irq_en_i);
endmodule

// File: rtl/uart_fifo_irq_chk.sv
`timescale 1ns/1ps
module uart_fifo_irq_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_push_i,
  input logic          tx_pop_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic [LW-1:0] tx_wmark_i,
  input logic [LW-1:0] rx_wmark_i,
  input logic [3:0]    irq_en_i,
  input logic          clr_we_i,
  input logic [3:0]    clr_data_i,
  input logic [LW-1:0] tx_level_o,
  input logic [LW-1:0] rx_level_o,
  input logic [3:0]    irq_status_o,
  input logic          irq_o
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [3:0] keep;
  assign keep = irq_status_o & ~(clr_we_i ? clr_data_i : 4'b0);

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= FULL_LVL) && (rx_level_o <= FULL_LVL)); // R1

  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_pop_i) |=> $stable(rx_level_o)); // R1

  AST_TX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && !tx_pop_i && tx_level_o == FULL_LVL) |=> (tx_level_o == FULL_LVL)); // R2

  AST_TX_WM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(tx_wmark_i) && $past(tx_level_o) >= tx_wmark_i && tx_level_o < tx_wmark_i)
      |-> irq_status_o[0]); // R4

  AST_TX_EMPTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_level_o) != '0 && tx_level_o == '0) |-> irq_status_o[1]); // R5

  AST_RX_WM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rx_wmark_i) && $past(rx_level_o) < rx_wmark_i && rx_level_o >= rx_wmark_i)
      |-> irq_status_o[2]); // R6

  AST_RX_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && rx_level_o == FULL_LVL)
      |=> (irq_status_o[3] && rx_level_o == FULL_LVL)); // R7

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_status_o & $past(keep)) == $past(keep))); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((irq_en_i & irq_status_o) != 4'b0)); // R11
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i),
  .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
  .tx_wmark_i(tx_wmark_i), .rx_wmark_i(rx_wmark_i),
  .irq_en_i(irq_en_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
  .tx_level_o(tx_level_o), .rx_level_o(rx_level_o),
  .irq_status_o(irq_status_o), .irq_o(irq_o)
);

// File: tb/uart_fifo_irq_test.sv
`timescale 1ns/1ps
module uart_fifo_irq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_push_i = 0, tx_pop_i = 0, rx_push_i = 0, rx_pop_i = 0;
  logic [4:0] tx_wmark_i = 5'd4, rx_wmark_i = 5'd16;
  logic [3:0] irq_en_i = 4'b0;
  logic       clr_we_i = 0;
  logic [3:0] clr_data_i = 4'b0;
  logic [4:0] tx_level_o, rx_level_o;
  logic [3:0] irq_status_o;
  logic       irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_fifo_irq uut (.*);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic tx_push(int n);
    for (int i = 0; i < n; i++) begin tx_push_i = 1; tick(); tx_push_i = 0; end
  endtask
  task automatic tx_pop(int n);
    for (int i = 0; i < n; i++) begin tx_pop_i = 1; tick(); tx_pop_i = 0; end
  endtask
  task automatic rx_push(int n);
    for (int i = 0; i < n; i++) begin rx_push_i = 1; tick(); rx_push_i = 0; end
  endtask
  task automatic rx_pop(int n);
    for (int i = 0; i < n; i++) begin rx_pop_i = 1; tick(); rx_pop_i = 0; end
  endtask
  task automatic clr(logic [3:0] m);
    clr_we_i = 1; clr_data_i = m; tick(); clr_we_i = 0; clr_data_i = 0;
  endtask

  task automatic t_reset();
    check("R3 tx level", tx_level_o, 0);
    check("R3 rx level", rx_level_o, 0);
    check("R3 status", irq_status_o, 0);
    check("R3 irq", irq_o, 0);
  endtask

  task automatic t_tx_watermark();
    tx_push(6);
    check("R1 tx level up", tx_level_o, 6);
    check("R4 no set on rise", irq_status_o, 0);
    tx_pop(2);
    check("R4 at watermark", irq_status_o, 0);
    tx_pop(1);
    check("R4 below watermark", irq_status_o, 4'b0001);
    tx_pop(3);
    check("R5 tx empty", irq_status_o, 4'b0011);
    tx_pop(1);
    check("R1 pop on empty", tx_level_o, 0);
  endtask

  task automatic t_clear();
    clr(4'b0000);
    check("R8 write zero", irq_status_o, 4'b0011);
    clr(4'b0001);
    check("R8 clear bit0", irq_status_o, 4'b0010);
    clr(4'b0010);
    check("R8 clear bit1", irq_status_o, 0);
  endtask

  task automatic t_rearm();
    tx_push(1); tx_pop(1);
    check("R9 wm stays clear", irq_status_o, 4'b0010);
    clr(4'b1111);
    tx_push(4); tx_pop(1);
    check("R9 wm rearmed", irq_status_o, 4'b0001);
    tx_pop(3); clr(4'b1111);
  endtask

  task automatic t_tx_bounds();
    tx_wmark_i = 5'd16; tick();
    tx_push(16);
    check("R1 tx full level", tx_level_o, 16);
    tx_push(1);
    check("R2 tx full drop level", tx_level_o, 16);
    check("R2 no tx overflow", irq_status_o, 0);
    tx_pop(1);
    check("R4 wm16 at 15", irq_status_o, 4'b0001);
    clr(4'b1111);
    tx_wmark_i = 5'd1; tick();
    check("R4 wm change alone", irq_status_o, 0);
    tx_pop(14);
    check("R4 wm1 at 1", irq_status_o, 0);
    tx_pop(1);
    check("R4 wm1 at empty", irq_status_o, 4'b0011);
    clr(4'b1111);
  endtask

  task automatic t_rx_watermark();
    rx_wmark_i = 5'd1; tick();
    rx_push(1);
    check("R6 wm1 single byte", irq_status_o, 4'b0100);
    rx_pop(1); clr(4'b1111);
    rx_wmark_i = 5'd3; tick();
    rx_push(2);
    check("R6 below wm3", irq_status_o, 0);
    rx_push(1);
    check("R6 reach wm3", irq_status_o, 4'b0100);
    rx_push_i = 1; rx_pop_i = 1; tick(); rx_push_i = 0; rx_pop_i = 0;
    check("R1 push and pop", rx_level_o, 3);
    rx_pop(3); clr(4'b1111);
  endtask

  task automatic t_rx_overflow();
    rx_wmark_i = 5'd16; tick();
    rx_push(16); clr(4'b1111);
    rx_push(1);
    check("R7 ovf level", rx_level_o, 16);
    check("R7 ovf status", irq_status_o, 4'b1000);
    clr(4'b1111);
    rx_push_i = 1; rx_pop_i = 1; tick(); rx_push_i = 0; rx_pop_i = 0;
    check("R7 push+pop full no ovf", irq_status_o, 0);
    check("R1 full push+pop level", rx_level_o, 16);
    rx_pop(16); clr(4'b1111);
  endtask

  task automatic t_set_wins();
    rx_wmark_i = 5'd1; tick();
    rx_push_i = 1; clr_we_i = 1; clr_data_i = 4'b1111; tick();
    rx_push_i = 0; clr_we_i = 0; clr_data_i = 0;
    check("R10 set beats clear", irq_status_o, 4'b0100);
  endtask

  task automatic t_mask();
    irq_en_i = 4'b0000; #1;
    check("R11 masked", irq_o, 0);
    irq_en_i = 4'b1011; #1;
    check("R11 other enables", irq_o, 0);
    irq_en_i = 4'b0100; #1;
    check("R11 enabled", irq_o, 1);
    clr(4'b0100);
    check("R11 after clear", irq_o, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    t_reset();
    t_tx_watermark();
    t_clear();
    t_rearm();
    t_tx_bounds();
    t_rx_watermark();
    t_rx_overflow();
    t_set_wins();
    t_mask();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule